// File: doc/BRIEF.md
# NVMe Host Queue Doorbell Engine

This block keeps the host-side pointer state for a small, parameterised set of NVMe queue pairs. Each pair has a submission ring and a completion ring. For each pair it holds both ring base addresses, the index of the last ring slot, the submission tail, the completion head and the most recent submission head reported by the controller. When software asks for a new submission slot, the block gives back the memory address of the slot to fill, or it refuses the request because the ring is full. When software consumes a completion, the block gives back the address of the completion entry and moves the head forward.

Doorbell writes are separate from slot allocation. Software can fill several submission slots and then ask for a single tail doorbell write. Consuming a completion always queues a head doorbell write. Pending doorbells are held as one flag per doorbell register. Each write goes out on a valid/ready register-write port with a register offset derived from the queue number and a doorbell stride, an 8-byte lane enable, and the index value the pointer holds at the moment the write is loaded.

Top module: `nvme_dbell_engine`

## Requirements
- R1: After reset, db_valid, sq_resp_valid and cq_resp_valid are 0, and every queue is disabled.
- R2: The tail doorbell of queue y is written at offset 0x1000 + ((2*y) << (2+S)) and its head doorbell at 0x1000 + ((2*y+1) << (2+S)). S is the dstrd value captured by the most recent accepted configuration write. With S=0, queue 0 uses 0x1000 and 0x1004.
- R3: One cycle after sq_push, sq_resp_valid is 1 and sq_resp_addr equals the submission base + tail*64. If the push is accepted, the tail advances by one.
- R4: One cycle after cq_pop on an enabled queue, cq_resp_ok is 1 and cq_resp_addr equals the completion base + head*16. The head advances, and a head doorbell carrying the new head is queued.
- R5: A tail or head index equal to the queue's last-slot index (cfg_last, which is the entry count minus one) advances to 0.
- R6: A push is refused (sq_resp_ok=0, tail unchanged) when the advanced tail would equal the last submission head reported through sq_head_upd.
- R7: sq_ring queues one tail doorbell. Its data is the tail value at the time the write is loaded, so several pushes followed by one ring produce one write that carries the updated tail.
- R8: Every doorbell write has db_be = 8'hFF. The index sits in the low bits of db_data and all higher bits are zero.
- R9: Base, size and stride writes aimed at an enabled queue are ignored. Enabling a disabled queue resets its tail, head and known submission head to 0.
- R10: When several doorbells are pending, the lowest doorbell number (2*y for a tail, 2*y+1 for a head) goes first. While db_ready is 0, db_valid, db_addr and db_data hold.
- R11: On a disabled queue, sq_push is refused, cq_pop returns cq_resp_ok=0, and neither sq_ring nor cq_pop queues a doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dstrd | input | 4 | Doorbell stride, captured on an accepted configuration write |
| cfg_we | input | 1 | Write base addresses and size of queue cfg_qid |
| cfg_qid | input | QID_W | Queue addressed by the configuration write |
| cfg_sq_base | input | ADDR_W | Submission ring base address |
| cfg_cq_base | input | ADDR_W | Completion ring base address |
| cfg_last | input | IDX_W | Index of the last slot (entries minus one) |
| en_we | input | 1 | Write the enable of queue en_qid |
| en_qid | input | QID_W | Queue addressed by the enable write |
| en_val | input | 1 | New enable value |
| sq_push | input | 1 | Allocate the next submission slot |
| sq_push_qid | input | QID_W | Queue for sq_push |
| sq_resp_valid | output | 1 | Push response present |
| sq_resp_ok | output | 1 | Push accepted |
| sq_resp_addr | output | ADDR_W | Address of the submission slot |
| sq_ring | input | 1 | Queue a tail doorbell write |
| sq_ring_qid | input | QID_W | Queue for sq_ring |
| sq_head_upd | input | 1 | Report the controller's submission head |
| sq_head_qid | input | QID_W | Queue for sq_head_upd |
| sq_head_val | input | IDX_W | Reported submission head |
| cq_pop | input | 1 | Consume one completion entry |
| cq_pop_qid | input | QID_W | Queue for cq_pop |
| cq_resp_valid | output | 1 | Pop response present |
| cq_resp_ok | output | 1 | Pop accepted |
| cq_resp_addr | output | ADDR_W | Address of the consumed completion entry |
| db_valid | output | 1 | Doorbell write request valid |
| db_ready | input | 1 | Doorbell write accepted |
| db_addr | output | 32 | Doorbell register offset |
| db_data | output | 64 | Doorbell write data |
| db_be | output | 8 | Byte enables of the doorbell write |

## Verification
The bench builds the block with four queue pairs, a 40-bit address and a 4-bit index. Rings are therefore at most sixteen entries deep, so wrap-around, full-ring refusal and head overtaking are all hit many times within a few thousand random cycles. Four queues give eight doorbells, enough to exercise priority between tail and head doorbells of different queues. Stride values from 0 to 5 move the offsets well away from the default layout. The directed part pins exact offsets, slot addresses and refusal points. The random part then compares the block against a behavioural model on every clock while db_ready is throttled.

// File: rtl/nvme_dbell_pkg.sv
package nvme_dbell_pkg;

   // log2 of the entry sizes in bytes
   localparam int unsigned SQE_SHIFT = 6;
   localparam int unsigned CQE_SHIFT = 4;

   localparam logic [31:0] DB_REGION = 32'h0000_1000;
   localparam int unsigned DB_DATA_W = 64;
   localparam int unsigned DB_BE_W   = DB_DATA_W / 8;

   typedef enum logic {
      DB_KIND_TAIL = 1'b0,
      DB_KIND_HEAD = 1'b1
   } db_kind_e;

   // Register offset of doorbell number n (2*q for a tail, 2*q+1 for a head).
   function automatic logic [31:0] db_offset(input logic [15:0] n, input logic [3:0] stride);
      return DB_REGION + (32'(n) << (5'd2 + 5'(stride)));
   endfunction

endpackage

// File: rtl/nvme_slot_addr.sv
module nvme_slot_addr #(
   parameter int unsigned ADDR_W = 48,
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned SHIFT  = 6
)(
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam int unsigned SPAN_W = IDX_W + SHIFT;

   if (SPAN_W > ADDR_W) begin : g_bad_span
      $error("nvme_slot_addr: ring span wider than address");
   end

   assign addr = base + (ADDR_W'(idx) << SHIFT);

endmodule

// File: rtl/nvme_qpair_regs.sv
module nvme_qpair_regs #(
   parameter int unsigned ADDR_W = 48,
   parameter int unsigned IDX_W  = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_sq_base,
   input  logic [ADDR_W-1:0] cfg_cq_base,
   input  logic [IDX_W-1:0]  cfg_last,
   input  logic              en_we,
   input  logic              en_val,
   input  logic              push,
   input  logic              pop,
   input  logic              head_upd,
   input  logic [IDX_W-1:0]  head_val,
   output logic              en,
   output logic [ADDR_W-1:0] sq_base,
   output logic [ADDR_W-1:0] cq_base,
   output logic [IDX_W-1:0]  tail,
   output logic [IDX_W-1:0]  head,
   output logic              push_ok
);
   logic [IDX_W-1:0] last_q;
   logic [IDX_W-1:0] sq_head_q;
   logic [IDX_W-1:0] tail_nxt;
   logic [IDX_W-1:0] head_nxt;
   logic             arm;

   assign tail_nxt = (tail == last_q) ? '0 : tail + IDX_W'(1);
   assign head_nxt = (head == last_q) ? '0 : head + IDX_W'(1);
   assign push_ok  = en && (tail_nxt != sq_head_q);
   assign arm      = en_we && en_val && !en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en        <= 1'b0;
         sq_base   <= '0;
         cq_base   <= '0;
         last_q    <= '0;
         tail      <= '0;
         head      <= '0;
         sq_head_q <= '0;
      end else begin
         if (cfg_we && !en) begin
            sq_base <= cfg_sq_base;
            cq_base <= cfg_cq_base;
            last_q  <= cfg_last;
         end
         if (en_we) begin
            en <= en_val;
         end
         if (arm) begin
            tail      <= '0;
            head      <= '0;
            sq_head_q <= '0;
         end else if (en) begin
            if (push && push_ok) begin
               tail <= tail_nxt;
            end
            if (pop) begin
               head <= head_nxt;
            end
            if (head_upd) begin
               sq_head_q <= head_val;
            end
         end
      end
   end

endmodule

// File: rtl/nvme_dbell_issue.sv
module nvme_dbell_issue
   import nvme_dbell_pkg::*;
#(
   parameter int unsigned NDB   = 8,
   parameter int unsigned IDX_W = 8
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NDB-1:0]             set,
   input  logic [NDB-1:0][IDX_W-1:0]  idx_vec,
   input  logic [3:0]                 stride,
   input  logic                       ready,
   output logic                       valid,
   output logic [31:0]                addr,
   output logic [DB_DATA_W-1:0]       data,
   output logic [DB_BE_W-1:0]         be
);
   localparam int unsigned DBI_W = (NDB > 1) ? $clog2(NDB) : 1;

   logic [NDB-1:0]   pend;
   logic [NDB-1:0]   clr;
   logic [DBI_W-1:0] pick;
   logic             hit;
   logic             load;

   always_comb begin
      hit  = 1'b0;
      pick = '0;
      for (int k = NDB - 1; k >= 0; k--) begin
         if (pend[k]) begin
            hit  = 1'b1;
            pick = DBI_W'(k);
         end
      end
   end

   assign load = !valid || ready;
   assign clr  = (load && hit) ? (NDB'(1) << pick) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend  <= '0;
         valid <= 1'b0;
         addr  <= '0;
         data  <= '0;
         be    <= '0;
      end else begin
         pend <= (pend & ~clr) | set;
         if (load) begin
            valid <= hit;
            be    <= hit ? '1 : '0;
            if (hit) begin
               addr <= db_offset(16'(pick), stride);
               data <= DB_DATA_W'(idx_vec[pick]);
            end
         end
      end
   end

endmodule

// File: rtl/nvme_dbell_engine.sv
module nvme_dbell_engine
   import nvme_dbell_pkg::*;
#(
   parameter int unsigned NQ     = 4,
   parameter int unsigned ADDR_W = 48,
   parameter int unsigned IDX_W  = 8,
   localparam int unsigned QID_W = (NQ > 1) ? $clog2(NQ) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        dstrd,
   input  logic              cfg_we,
   input  logic [QID_W-1:0]  cfg_qid,
   input  logic [ADDR_W-1:0] cfg_sq_base,
   input  logic [ADDR_W-1:0] cfg_cq_base,
   input  logic [IDX_W-1:0]  cfg_last,
   input  logic              en_we,
   input  logic [QID_W-1:0]  en_qid,
   input  logic              en_val,
   input  logic              sq_push,
   input  logic [QID_W-1:0]  sq_push_qid,
   output logic              sq_resp_valid,
   output logic              sq_resp_ok,
   output logic [ADDR_W-1:0] sq_resp_addr,
   input  logic              sq_ring,
   input  logic [QID_W-1:0]  sq_ring_qid,
   input  logic              sq_head_upd,
   input  logic [QID_W-1:0]  sq_head_qid,
   input  logic [IDX_W-1:0]  sq_head_val,
   input  logic              cq_pop,
   input  logic [QID_W-1:0]  cq_pop_qid,
   output logic              cq_resp_valid,
   output logic              cq_resp_ok,
   output logic [ADDR_W-1:0] cq_resp_addr,
   output logic              db_valid,
   input  logic              db_ready,
   output logic [31:0]       db_addr,
   output logic [63:0]       db_data,
   output logic [7:0]        db_be
);
   localparam int unsigned NDB = 2 * NQ;

   if (NQ < 1 || NQ > 64) begin : g_bad_nq
      $error("nvme_dbell_engine: NQ out of range");
   end
   if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
      $error("nvme_dbell_engine: IDX_W out of range");
   end
   if (ADDR_W < IDX_W + SQE_SHIFT || ADDR_W > 64) begin : g_bad_addr
      $error("nvme_dbell_engine: ADDR_W out of range");
   end

   logic [NQ-1:0]             q_en, q_push_ok;
   logic [NQ-1:0]             sel_cfg, sel_en, sel_push, sel_pop, sel_ring, sel_hu;
   logic [NQ-1:0][ADDR_W-1:0] q_sqb, q_cqb;
   logic [NQ-1:0][IDX_W-1:0]  q_tail, q_head;
   logic [NDB-1:0]            db_set;
   logic [NDB-1:0][IDX_W-1:0] db_idx;
   logic [3:0]                stride_q;

   for (genvar y = 0; y < NQ; y++) begin : g_q
      assign sel_cfg[y]  = (cfg_qid == QID_W'(y));
      assign sel_en[y]   = (en_qid == QID_W'(y));
      assign sel_push[y] = (sq_push_qid == QID_W'(y));
      assign sel_pop[y]  = (cq_pop_qid == QID_W'(y));
      assign sel_ring[y] = (sq_ring_qid == QID_W'(y));
      assign sel_hu[y]   = (sq_head_qid == QID_W'(y));

      nvme_qpair_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
         .clk         (clk),
         .rst_n       (rst_n),
         .cfg_we      (cfg_we && sel_cfg[y]),
         .cfg_sq_base (cfg_sq_base),
         .cfg_cq_base (cfg_cq_base),
         .cfg_last    (cfg_last),
         .en_we       (en_we && sel_en[y]),
         .en_val      (en_val),
         .push        (sq_push && sel_push[y]),
         .pop         (cq_pop && sel_pop[y]),
         .head_upd    (sq_head_upd && sel_hu[y]),
         .head_val    (sq_head_val),
         .en          (q_en[y]),
         .sq_base     (q_sqb[y]),
         .cq_base     (q_cqb[y]),
         .tail        (q_tail[y]),
         .head        (q_head[y]),
         .push_ok     (q_push_ok[y])
      );

      assign db_set[2*y]   = sq_ring && sel_ring[y] && q_en[y];
      assign db_set[2*y+1] = cq_pop && sel_pop[y] && q_en[y];
      assign db_idx[2*y]   = q_tail[y];
      assign db_idx[2*y+1] = q_head[y];
   end

   // Operand selection for the two slot address computations
   logic [ADDR_W-1:0] p_base, c_base, p_addr, c_addr;
   logic [IDX_W-1:0]  p_idx, c_idx;
   logic              p_ok, c_ok, cfg_open;

   always_comb begin
      p_base   = '0;
      p_idx    = '0;
      p_ok     = 1'b0;
      c_base   = '0;
      c_idx    = '0;
      c_ok     = 1'b0;
      cfg_open = 1'b0;
      for (int y = 0; y < NQ; y++) begin
         if (sel_push[y]) begin
            p_base = q_sqb[y];
            p_idx  = q_tail[y];
            p_ok   = q_push_ok[y];
         end
         if (sel_pop[y]) begin
            c_base = q_cqb[y];
            c_idx  = q_head[y];
            c_ok   = q_en[y];
         end
         if (sel_cfg[y]) begin
            cfg_open = !q_en[y];
         end
      end
   end

   nvme_slot_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SHIFT(SQE_SHIFT)) u_sq_slot (
      .base (p_base),
      .idx  (p_idx),
      .addr (p_addr)
   );

   nvme_slot_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SHIFT(CQE_SHIFT)) u_cq_slot (
      .base (c_base),
      .idx  (c_idx),
      .addr (c_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stride_q      <= '0;
         sq_resp_valid <= 1'b0;
         sq_resp_ok    <= 1'b0;
         sq_resp_addr  <= '0;
         cq_resp_valid <= 1'b0;
         cq_resp_ok    <= 1'b0;
         cq_resp_addr  <= '0;
      end else begin
         if (cfg_we && cfg_open) begin
            stride_q <= dstrd;
         end
         sq_resp_valid <= sq_push;
         cq_resp_valid <= cq_pop;
         if (sq_push) begin
            sq_resp_ok   <= p_ok;
            sq_resp_addr <= p_addr;
         end
         if (cq_pop) begin
            cq_resp_ok   <= c_ok;
            cq_resp_addr <= c_addr;
         end
      end
   end

   nvme_dbell_issue #(.NDB(NDB), .IDX_W(IDX_W)) u_issue (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (db_set),
      .idx_vec (db_idx),
      .stride  (stride_q),
      .ready   (db_ready),
      .valid   (db_valid),
      .addr    (db_addr),
      .data    (db_data),
      .be      (db_be)
   );

endmodule

// File: rtl/nvme_dbell_engine_chk.sv
module nvme_dbell_engine_chk #(
   parameter int unsigned IDX_W = 8
)(
   input logic        clk,
   input logic        rst_n,
   input logic        sq_push,
   input logic        sq_resp_valid,
   input logic        cq_pop,
   input logic        cq_resp_valid,
   input logic        db_valid,
   input logic        db_ready,
   input logic [31:0] db_addr,
   input logic [63:0] db_data,
   input logic [7:0]  db_be
);
   // R10
   db_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (db_valid && !db_ready) |=> (db_valid && $stable(db_addr) && $stable(db_data)));

   // R8
   db_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      db_valid |-> (db_be == 8'hFF && db_data[63:IDX_W] == '0));

   // R2
   db_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      db_valid |-> (db_addr >= 32'h0000_1000 && db_addr[1:0] == 2'b00));

   // R3
   sq_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sq_resp_valid |-> $past(sq_push));

   // R4
   cq_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cq_resp_valid |-> $past(cq_pop));

endmodule

bind nvme_dbell_engine nvme_dbell_engine_chk #(.IDX_W(IDX_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sq_push       (sq_push),
   .sq_resp_valid (sq_resp_valid),
   .cq_pop        (cq_pop),
   .cq_resp_valid (cq_resp_valid),
   .db_valid      (db_valid),
   .db_ready      (db_ready),
   .db_addr       (db_addr),
   .db_data       (db_data),
   .db_be         (db_be)
);

// File: tb/nvme_dbell_engine_tb.sv
`timescale 1ns/1ps
module nvme_dbell_engine_tb;
   localparam int NQ = 4;
   localparam int ADDR_W = 40;
   localparam int IDX_W = 4;
   localparam int QW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [3:0] dstrd;
   logic cfg_we, en_we, en_val, sq_push, sq_ring, sq_head_upd, cq_pop, db_ready;
   logic [QW-1:0] cfg_qid, en_qid, sq_push_qid, sq_ring_qid, sq_head_qid, cq_pop_qid;
   logic [ADDR_W-1:0] cfg_sq_base, cfg_cq_base;
   logic [IDX_W-1:0] cfg_last, sq_head_val;
   logic sq_resp_valid, sq_resp_ok, cq_resp_valid, cq_resp_ok, db_valid;
   logic [ADDR_W-1:0] sq_resp_addr, cq_resp_addr;
   logic [31:0] db_addr;
   logic [63:0] db_data;
   logic [7:0] db_be;

   nvme_dbell_engine #(.NQ(NQ), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .dstrd(dstrd),
      .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_sq_base(cfg_sq_base),
      .cfg_cq_base(cfg_cq_base), .cfg_last(cfg_last),
      .en_we(en_we), .en_qid(en_qid), .en_val(en_val),
      .sq_push(sq_push), .sq_push_qid(sq_push_qid),
      .sq_resp_valid(sq_resp_valid), .sq_resp_ok(sq_resp_ok), .sq_resp_addr(sq_resp_addr),
      .sq_ring(sq_ring), .sq_ring_qid(sq_ring_qid),
      .sq_head_upd(sq_head_upd), .sq_head_qid(sq_head_qid), .sq_head_val(sq_head_val),
      .cq_pop(cq_pop), .cq_pop_qid(cq_pop_qid),
      .cq_resp_valid(cq_resp_valid), .cq_resp_ok(cq_resp_ok), .cq_resp_addr(cq_resp_addr),
      .db_valid(db_valid), .db_ready(db_ready), .db_addr(db_addr),
      .db_data(db_data), .db_be(db_be)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit cmp_on = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit               m_en[NQ];
   logic [ADDR_W-1:0] m_sqb[NQ], m_cqb[NQ];
   int               m_last[NQ], m_tail[NQ], m_head[NQ], m_sqh[NQ];
   bit               m_pend[2*NQ];
   int               m_stride;
   bit               m_dbv, m_sqrv, m_sqrok, m_cqrv, m_cqrok;
   longint           m_dba, m_dbd;
   int               m_be;
   logic [ADDR_W-1:0] m_sqra, m_cqra;

   bit               o_en[NQ];
   int               o_last[NQ], o_tail[NQ], o_head[NQ], o_sqh[NQ];
   bit               o_pend[2*NQ];

   always @(posedge clk) begin : model
      int k, q, nx, ost;
      if (!rst_n) begin
         for (int i = 0; i < NQ; i++) begin
            m_en[i] = 0; m_sqb[i] = '0; m_cqb[i] = '0;
            m_last[i] = 0; m_tail[i] = 0; m_head[i] = 0; m_sqh[i] = 0;
         end
         for (int i = 0; i < 2*NQ; i++) m_pend[i] = 0;
         m_stride = 0; m_dbv = 0; m_dba = 0; m_dbd = 0; m_be = 0;
         m_sqrv = 0; m_sqrok = 0; m_sqra = '0; m_cqrv = 0; m_cqrok = 0; m_cqra = '0;
      end else begin
         o_en = m_en; o_last = m_last; o_tail = m_tail; o_head = m_head;
         o_sqh = m_sqh; o_pend = m_pend; ost = m_stride;
         if (!m_dbv || db_ready) begin
            k = -1;
            for (int i = 2*NQ-1; i >= 0; i--) if (o_pend[i]) k = i;
            m_dbv = (k >= 0);
            m_be = m_dbv ? 255 : 0;
            if (k >= 0) begin
               m_dba = 64'h1000 + (longint'(k) << (2 + ost));
               m_dbd = (k % 2 == 0) ? o_tail[k/2] : o_head[k/2];
               m_pend[k] = 0;
            end
         end
         m_sqrv = sq_push;
         if (sq_push) begin
            q = int'(sq_push_qid);
            nx = (o_tail[q] == o_last[q]) ? 0 : o_tail[q] + 1;
            m_sqrok = o_en[q] && (nx != o_sqh[q]);
            m_sqra = m_sqb[q] + ADDR_W'(o_tail[q] * 64);
            if (m_sqrok) m_tail[q] = nx;
         end
         m_cqrv = cq_pop;
         if (cq_pop) begin
            q = int'(cq_pop_qid);
            nx = (o_head[q] == o_last[q]) ? 0 : o_head[q] + 1;
            m_cqrok = o_en[q];
            m_cqra = m_cqb[q] + ADDR_W'(o_head[q] * 16);
            if (o_en[q]) begin
               m_head[q] = nx;
               m_pend[2*q+1] = 1;
            end
         end
         if (sq_ring && o_en[int'(sq_ring_qid)]) m_pend[2*int'(sq_ring_qid)] = 1;
         if (sq_head_upd && o_en[int'(sq_head_qid)]) m_sqh[int'(sq_head_qid)] = int'(sq_head_val);
         if (cfg_we && !o_en[int'(cfg_qid)]) begin
            q = int'(cfg_qid);
            m_sqb[q] = cfg_sq_base; m_cqb[q] = cfg_cq_base; m_last[q] = int'(cfg_last);
            m_stride = int'(dstrd);
         end
         if (en_we) begin
            q = int'(en_qid);
            if (en_val && !o_en[q]) begin
               m_tail[q] = 0; m_head[q] = 0; m_sqh[q] = 0;
            end
            m_en[q] = en_val;
         end
      end
   end

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (cmp_on && rst_n && !done) begin
         chk(db_valid == m_dbv, "R10", "db_valid vs model", longint'(db_valid), longint'(m_dbv));
         if (db_valid && m_dbv) begin
            chk(longint'(db_addr) == m_dba, "R2", "db_addr vs model", longint'(db_addr), m_dba);
            chk(longint'(db_data) == m_dbd, "R7", "db_data vs model", longint'(db_data), m_dbd);
         end
         chk(int'(db_be) == m_be, "R8", "db_be vs model", longint'(db_be), longint'(m_be));
         chk(sq_resp_valid == m_sqrv, "R3", "sq_resp_valid vs model", longint'(sq_resp_valid), longint'(m_sqrv));
         if (sq_resp_valid && m_sqrv) begin
            chk(sq_resp_ok == m_sqrok, "R6", "sq_resp_ok vs model", longint'(sq_resp_ok), longint'(m_sqrok));
            chk(sq_resp_addr == m_sqra, "R3", "sq_resp_addr vs model", longint'(sq_resp_addr), longint'(m_sqra));
         end
         chk(cq_resp_valid == m_cqrv, "R4", "cq_resp_valid vs model", longint'(cq_resp_valid), longint'(m_cqrv));
         if (cq_resp_valid && m_cqrv) begin
            chk(cq_resp_ok == m_cqrok, "R11", "cq_resp_ok vs model", longint'(cq_resp_ok), longint'(m_cqrok));
            chk(cq_resp_addr == m_cqra, "R4", "cq_resp_addr vs model", longint'(cq_resp_addr), longint'(m_cqra));
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle();
      cfg_we = 0; en_we = 0; sq_push = 0; sq_ring = 0; sq_head_upd = 0; cq_pop = 0;
   endtask

   task automatic cfg(input int q, input longint sb, input longint cb, input int last, input int st);
      @(negedge clk);
      idle(); cfg_we = 1; cfg_qid = QW'(q); cfg_sq_base = ADDR_W'(sb);
      cfg_cq_base = ADDR_W'(cb); cfg_last = IDX_W'(last); dstrd = 4'(st);
      @(negedge clk); idle();
   endtask

   task automatic enable(input int q, input bit v);
      @(negedge clk);
      idle(); en_we = 1; en_qid = QW'(q); en_val = v;
      @(negedge clk); idle();
   endtask

   task automatic head_upd(input int q, input int v);
      @(negedge clk);
      idle(); sq_head_upd = 1; sq_head_qid = QW'(q); sq_head_val = IDX_W'(v);
      @(negedge clk); idle();
   endtask

   task automatic do_push(input int q, input bit exp_ok, input longint exp_addr, input string req);
      @(negedge clk);
      idle(); sq_push = 1; sq_push_qid = QW'(q);
      @(negedge clk); idle();
      chk(sq_resp_valid == 1'b1, req, "push response valid", longint'(sq_resp_valid), 1);
      chk(sq_resp_ok == exp_ok, req, "push accepted", longint'(sq_resp_ok), longint'(exp_ok));
      if (exp_ok) chk(longint'(sq_resp_addr) == exp_addr, req, "push slot address",
                      longint'(sq_resp_addr), exp_addr);
   endtask

   task automatic do_pop(input int q, input bit exp_ok, input longint exp_addr, input string req);
      @(negedge clk);
      idle(); cq_pop = 1; cq_pop_qid = QW'(q);
      @(negedge clk); idle();
      chk(cq_resp_ok == exp_ok, req, "pop accepted", longint'(cq_resp_ok), longint'(exp_ok));
      if (exp_ok) chk(longint'(cq_resp_addr) == exp_addr, req, "pop entry address",
                      longint'(cq_resp_addr), exp_addr);
   endtask

   task automatic do_ring(input int q);
      @(negedge clk);
      idle(); sq_ring = 1; sq_ring_qid = QW'(q);
      @(negedge clk); idle();
   endtask

   task automatic wait_db(input longint exp_addr, input longint exp_data, input string req);
      for (int i = 0; i < 8; i++) begin
         if (db_valid) break;
         @(negedge clk);
      end
      chk(db_valid == 1'b1, req, "doorbell issued", longint'(db_valid), 1);
      chk(longint'(db_addr) == exp_addr, req, "doorbell offset", longint'(db_addr), exp_addr);
      chk(longint'(db_data) == exp_data, req, "doorbell value", longint'(db_data), exp_data);
      chk(db_be == 8'hFF, "R8", "doorbell byte enables", longint'(db_be), 255);
      @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(5.0 * 200000);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      idle(); dstrd = 0; db_ready = 1;
      cfg_qid = 0; en_qid = 0; en_val = 0; sq_push_qid = 0; sq_ring_qid = 0;
      sq_head_qid = 0; cq_pop_qid = 0; cfg_sq_base = '0; cfg_cq_base = '0;
      cfg_last = '0; sq_head_val = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(db_valid == 0, "R1", "db_valid in reset", longint'(db_valid), 0);
      chk(sq_resp_valid == 0 && cq_resp_valid == 0, "R1", "responses in reset",
          longint'({sq_resp_valid, cq_resp_valid}), 0);
      rst_n = 1;
      cmp_on = 1;
      @(negedge clk);
      do_push(0, 0, 0, "R1");   // every queue starts disabled

      // queue 0: four entries, stride 0
      cfg(0, 64'h10000, 64'h20000, 3, 0);
      enable(0, 1);
      do_push(0, 1, 64'h10000, "R3");
      do_push(0, 1, 64'h10040, "R3");
      do_push(0, 1, 64'h10080, "R3");
      do_push(0, 0, 0, "R6");
      do_ring(0);
      wait_db(64'h1000, 3, "R7");

      head_upd(0, 2);
      do_push(0, 1, 64'h100C0, "R3");
      do_push(0, 1, 64'h10000, "R5");
      do_push(0, 0, 0, "R6");

      do_pop(0, 1, 64'h20000, "R4");
      wait_db(64'h1004, 1, "R2");
      do_pop(0, 1, 64'h20010, "R4");
      wait_db(64'h1004, 2, "R4");
      do_pop(0, 1, 64'h20020, "R4");
      wait_db(64'h1004, 3, "R4");
      do_pop(0, 1, 64'h20030, "R4");
      wait_db(64'h1004, 0, "R5");
      do_pop(0, 1, 64'h20000, "R5");
      wait_db(64'h1004, 1, "R4");

      // config while enabled is ignored
      head_upd(0, 0);
      cfg(0, 64'h50000, 64'h60000, 7, 5);
      do_push(0, 1, 64'h10040, "R9");
      do_ring(0);
      wait_db(64'h1000, 2, "R9");

      // queue 1 with stride 2
      enable(0, 0);
      cfg(1, 64'h30000, 64'h40000, 1, 2);
      enable(1, 1);
      do_ring(1);
      wait_db(64'h1020, 0, "R2");
      do_pop(1, 1, 64'h40000, "R4");
      wait_db(64'h1030, 1, "R2");

      // disabled queue 0
      do_push(0, 0, 0, "R11");
      do_ring(0);
      do_pop(0, 0, 0, "R11");
      for (int i = 0; i < 4; i++) begin
         chk(db_valid == 0, "R11", "no doorbell from disabled queue", longint'(db_valid), 0);
         @(negedge clk);
      end

      // re-enable resets indices
      enable(0, 1);
      do_push(0, 1, 64'h10000, "R9");

      // priority and hold under back-pressure
      @(negedge clk);
      db_ready = 0;
      idle(); sq_ring = 1; sq_ring_qid = 1; cq_pop = 1; cq_pop_qid = 0;
      @(negedge clk); idle();
      @(negedge clk);
      chk(db_valid == 1, "R10", "first pending loaded", longint'(db_valid), 1);
      chk(db_addr == 32'h1010, "R10", "lowest doorbell first", longint'(db_addr), 64'h1010);
      chk(db_data == 64'd1, "R10", "head value", longint'(db_data), 1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(db_valid == 1 && db_addr == 32'h1010 && db_data == 64'd1, "R10",
             "held under back-pressure", longint'(db_addr), 64'h1010);
      end
      db_ready = 1;
      @(negedge clk);
      chk(db_valid == 1 && db_addr == 32'h1020, "R10", "second pending follows",
          longint'(db_addr), 64'h1020);
      chk(db_data == 64'd0, "R7", "second pending value", longint'(db_data), 0);
      @(negedge clk);

      // random traffic against the model
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         idle();
         db_ready = ($urandom_range(0, 9) < 6);
         if ($urandom_range(0, 99) < 5) begin
            cfg_we = 1; cfg_qid = QW'($urandom_range(0, NQ-1));
            cfg_sq_base = ADDR_W'({$urandom(), $urandom()});
            cfg_cq_base = ADDR_W'({$urandom(), $urandom()});
            cfg_last = IDX_W'($urandom_range(1, 15));
            dstrd = 4'($urandom_range(0, 5));
         end
         if ($urandom_range(0, 99) < 5) begin
            en_we = 1; en_qid = QW'($urandom_range(0, NQ-1));
            en_val = ($urandom_range(0, 3) != 0);
         end
         if ($urandom_range(0, 99) < 30) begin
            sq_push = 1; sq_push_qid = QW'($urandom_range(0, NQ-1));
         end
         if ($urandom_range(0, 99) < 15) begin
            sq_ring = 1; sq_ring_qid = QW'($urandom_range(0, NQ-1));
         end
         if ($urandom_range(0, 99) < 15) begin
            sq_head_upd = 1; sq_head_qid = QW'($urandom_range(0, NQ-1));
            sq_head_val = IDX_W'($urandom_range(0, m_last[int'(sq_head_qid)]));
         end
         if ($urandom_range(0, 99) < 20) begin
            cq_pop = 1; cq_pop_qid = QW'($urandom_range(0, NQ-1));
         end
      end
      @(negedge clk); idle(); db_ready = 1;
      repeat (20) @(negedge clk);

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule